// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block runs one complete NAND flash operation on an 8-bit flash bus. Software first loads the opcodes, the column address, the row address, the chip-enable and ready/busy selects, and the transfer size. It then writes a control word that holds a 16-bit cycle-select code and a start bit. Each bit of the code turns on one phase of the operation. The enabled phases always run in the same hardware order, and any phase left off is skipped. One code word can therefore express a bare reset command, an ID read, a status poll, a page read with a busy wait, or a page program, with no other reprogramming.

Write data comes from a local page buffer and read data lands in the same buffer. Each 32-bit buffer word is big-endian, so the byte that crosses the flash bus first sits in bits 31:24. When the last enabled phase finishes, the block sets its idle and done status bits. If interrupts are enabled, it also raises `irq`. Software reaches everything through a simple single-cycle register port. Word addresses with the top address bit set fall in the buffer; the others select registers.

Register map, by word address with the top address bit clear:
- 0 is the opcode register: bits 31:24 hold the second command opcode and bits 23:16 hold the third.
- 1 is the control register: bits 31:24 hold the first command opcode, bits 23:8 the code, bits 2:1 the buffer number, and bit 0 the start bit.
- 2 is the column address, in bits 15:0.
- 3 is the row register: bits 23:0 hold the row address, bits 27:24 the chip-enable select, and bits 31:28 the ready/busy select.
- 4 is the transfer size in bytes.
- 5 is the interrupt register.
- 6 is the status byte, read-only.
- 7 is the ID word, read-only.

Top module: `nand_seq`

## Requirements
- R1: After reset, every `ce_n` bit is high, `we_n` and `re_n` are high, `cle`, `ale`, `io_oe` and `irq` are low, and the control and interrupt registers read 0.
- R2: Command, address and write-data bytes each drive `io_out` with `io_oe` high while `we_n` is low for exactly T_WL clock cycles and then high for T_WH cycles. `cle` is high only for command bytes and `ale` only for address bytes. The flash latches the byte on the rising edge of `we_n`.
- R3: Step k of the operation is enabled by code bit 14-k. The steps are: bit 14 command 1, bits 13 and 12 column bytes, bits 11, 10 and 9 row bytes, bit 8 write data, bit 7 command 2, bit 6 ready/busy wait, bit 5 read data, bit 4 command 3, bit 3 status read, bit 2 ID read. Enabled steps run in that order and disabled steps produce no bus cycle.
- R4: Command 1 sends control bits 31:24, command 2 sends opcode bits 31:24, and command 3 sends opcode bits 23:16. The column bytes go out low byte first, followed by the row bytes low byte first.
- R5: The write-data step sends exactly SIZE bytes from buffer byte 0 upward. Buffer byte 4w+j is bits 31-8j down to 24-8j of word w. A data step with SIZE 0 is skipped.
- R6: Each read pulse holds `re_n` low for exactly T_RP cycles and samples `io_in` on the last low cycle. The read-data step stores SIZE bytes big-endian into the buffer from byte 0, and buffer bytes beyond SIZE keep their contents.
- R7: The ready/busy wait lasts at least T_WB cycles. It then ends only once every `rb_n` line selected by row register bits 31:28 is high. Unselected lines are ignored, and no strobe pulses while the wait runs.
- R8: A status read stores one byte in bits 7:0 of address 6. An ID read takes four bytes into address 7, with the first byte in bits 31:24.
- R9: Control bit 0 starts the operation when written while idle. It reads 1 while the operation runs and 0 once it is idle. While busy, writes to every register except the interrupt register, and to the buffer, are ignored. A code of 0 completes at once with no bus cycle.
- R10: Completion sets interrupt-register bit 29 (idle) and bit 30 (done). `irq` is bit 29 AND bit 20 (enable). Writing 1 to bit 17 clears idle and writing 1 to bit 18 clears done; a completion in the same cycle wins over a clear.
- R11: While busy, `ce_n[i]` is low exactly when row register bit 24+i is set, and it stays stable for the whole operation. Every `ce_n` bit is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register/buffer write strobe |
| bus_addr | input | ADDR_W | Word address; top bit selects the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Idle interrupt |
| ce_n | output | NCS | Chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Flash data out |
| io_oe | output | 1 | Output enable for `io_out` |
| io_in | input | 8 | Flash data in |
| rb_n | input | NCS | Ready/busy lines, low while busy |

## Verification
The bench runs several code words that switch on scattered subsets of phases. A sequencer that ignored a disabled bit, or ran steps in the wrong order, would log an extra or misplaced bus cycle. It also checks the column-then-row byte order and the big-endian order of buffer bytes, so a design that swapped either would send the address or the page data scrambled.

Other cases cover the data steps. A SIZE of zero would make a careless design pulse once or run for 4096 bytes. A partial read would let a design clobber the buffer bytes past the transfer.

The wait is held open on the selected ready/busy line while an unselected line stays low. In that window the bench writes a new start and a new column address. A design that leaked through the busy guard or watched the wrong line would either hang or restart.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int BUF_BYTES = 2304,
  parameter int NCS       = 4,
  parameter int T_WL      = 2,
  parameter int T_WH      = 2,
  parameter int T_RP      = 2,
  parameter int T_REH     = 2,
  parameter int T_WB      = 4,
  localparam int BUF_WORDS = BUF_BYTES / 4,
  localparam int BIDX_W    = $clog2(BUF_WORDS),
  localparam int ADDR_W    = BIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [NCS-1:0]    ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        io_out,
  output logic              io_oe,
  input  logic [7:0]        io_in,
  input  logic [NCS-1:0]    rb_n
);
  localparam int SZ_W   = $clog2(BUF_BYTES + 1);
  localparam int BI_W   = BIDX_W + 2;
  localparam int TCNT_W = $clog2(T_WL + T_WH + T_RP + T_REH + T_WB + 1);
  localparam logic [3:0] NONE = 4'd13;
  localparam logic [TCNT_W-1:0] L_WL = TCNT_W'(T_WL);
  localparam logic [TCNT_W-1:0] L_WH = TCNT_W'(T_WH);
  localparam logic [TCNT_W-1:0] L_RP = TCNT_W'(T_RP);
  localparam logic [TCNT_W-1:0] L_RH = TCNT_W'(T_REH);
  localparam logic [TCNT_W-1:0] L_WB = TCNT_W'(T_WB);

  logic [7:0]  mem [BUF_BYTES];
  logic [15:0] opc, code, col;
  logic [7:0]  op1, stat_b;
  logic [1:0]  bufno;
  logic [31:0] row, id_w;
  logic [SZ_W-1:0] size, bcnt;
  logic        idle_st, done_st, idle_en;
  logic        busy, ph;
  logic [3:0]  step;
  logic [TCNT_W-1:0] tcnt, lim;
  logic [NCS-1:0] rb_s1, rb_s2;
  logic [7:0]  out_byte;

  function automatic logic [3:0] pick(input logic [15:0] c, input logic [SZ_W-1:0] sz,
                                      input int from);
    logic [3:0] r;
    r = NONE;
    for (int s = 12; s >= 0; s--)
      if (s >= from && c[14-s] && !((s == 6 || s == 9) && sz == '0)) r = 4'(s);
    return r;
  endfunction

  wire is_cmd  = (step == 4'd0) || (step == 4'd7) || (step == 4'd10);
  wire is_adr  = (step >= 4'd1) && (step <= 4'd5);
  wire is_wrd  = (step == 4'd6);
  wire is_out  = is_cmd || is_adr || is_wrd;
  wire is_in   = (step == 4'd9) || (step == 4'd11) || (step == 4'd12);
  wire is_wait = (step == 4'd8);
  wire ready   = &(rb_s2 | ~row[28 +: NCS]);

  always_comb begin
    if (ph)           lim = is_in ? L_RH : L_WH;
    else if (is_wait) lim = L_WB;
    else              lim = is_in ? L_RP : L_WL;
  end
  wire tend  = (tcnt == lim - 1'b1);
  wire cap   = busy && is_in && !ph && tend;
  wire multi = ((is_wrd || step == 4'd9) && bcnt != size - 1'b1) ||
               (step == 4'd12 && bcnt[1:0] != 2'd3);

  always_comb begin
    case (step)
      4'd0:    out_byte = op1;
      4'd1:    out_byte = col[7:0];
      4'd2:    out_byte = col[15:8];
      4'd3:    out_byte = row[7:0];
      4'd4:    out_byte = row[15:8];
      4'd5:    out_byte = row[23:16];
      4'd6:    out_byte = mem[bcnt];
      4'd7:    out_byte = opc[15:8];
      4'd10:   out_byte = opc[7:0];
      default: out_byte = 8'h00;
    endcase
  end

  assign cle    = busy && is_cmd;
  assign ale    = busy && is_adr;
  assign io_oe  = busy && is_out;
  assign io_out = out_byte;
  assign we_n   = !(busy && is_out && !ph);
  assign re_n   = !(busy && is_in && !ph);
  assign ce_n   = busy ? ~row[24 +: NCS] : '1;
  assign irq    = idle_st & idle_en;

  wire [BIDX_W-1:0] widx = bus_addr[BIDX_W-1:0];
  wire [BI_W-1:0]   bi   = {widx, 2'b00};
  wire buf_ok = int'(widx) < BUF_WORDS;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1]) begin
      if (buf_ok) bus_rdata = {mem[bi], mem[bi + 1'b1], mem[bi + 2'd2], mem[bi + 2'd3]};
    end else begin
      case (bus_addr[2:0])
        3'd0: bus_rdata = {opc, 16'h0};
        3'd1: bus_rdata = {op1, code, 5'b0, bufno, busy};
        3'd2: bus_rdata = {16'h0, col};
        3'd3: bus_rdata = row;
        3'd4: bus_rdata = 32'(size);
        3'd5: bus_rdata = {1'b0, done_st, idle_st, 8'b0, idle_en, 20'b0};
        3'd6: bus_rdata = {24'h0, stat_b};
        default: bus_rdata = id_w;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (bus_we && bus_addr[ADDR_W-1] && !busy && buf_ok)
      for (int k = 0; k < 4; k++) mem[bi + BI_W'(k)] <= bus_wdata[31-8*k -: 8];
    if (cap && step == 4'd9) mem[bcnt] <= io_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc <= '0; code <= '0; col <= '0; op1 <= '0; stat_b <= '0; bufno <= '0;
      row <= '0; id_w <= '0; size <= '0; bcnt <= '0;
      idle_st <= 1'b0; done_st <= 1'b0; idle_en <= 1'b0;
      busy <= 1'b0; ph <= 1'b0; step <= NONE; tcnt <= '0;
      rb_s1 <= '1; rb_s2 <= '1;
    end else begin
      rb_s1 <= rb_n;
      rb_s2 <= rb_s1;
      if (bus_we && !bus_addr[ADDR_W-1]) begin
        case (bus_addr[2:0])
          3'd0: if (!busy) opc <= bus_wdata[31:16];
          3'd1: if (!busy) begin
            op1   <= bus_wdata[31:24];
            code  <= bus_wdata[23:8];
            bufno <= bus_wdata[2:1];
            if (bus_wdata[0]) begin
              bcnt <= '0; ph <= 1'b0; tcnt <= '0;
              if (pick(bus_wdata[23:8], size, 0) == NONE) begin
                idle_st <= 1'b1; done_st <= 1'b1;
              end else begin
                busy <= 1'b1;
                step <= pick(bus_wdata[23:8], size, 0);
              end
            end
          end
          3'd2: if (!busy) col <= bus_wdata[15:0];
          3'd3: if (!busy) row <= bus_wdata;
          3'd4: if (!busy) size <= bus_wdata[SZ_W-1:0];
          3'd5: begin
            idle_en <= bus_wdata[20];
            if (bus_wdata[17]) idle_st <= 1'b0;
            if (bus_wdata[18]) done_st <= 1'b0;
          end
          default: ;
        endcase
      end
      if (busy) begin
        if (cap && step == 4'd11) stat_b <= io_in;
        if (cap && step == 4'd12) id_w[8*(3-int'(bcnt[1:0])) +: 8] <= io_in;
        if (is_wait) begin
          if (!ph) begin
            if (tend) begin ph <= 1'b1; tcnt <= '0; end
            else tcnt <= tcnt + 1'b1;
          end else if (ready) begin
            ph <= 1'b0;
            if (pick(code, size, int'(step) + 1) == NONE) begin
              busy <= 1'b0; step <= NONE; idle_st <= 1'b1; done_st <= 1'b1;
            end else step <= pick(code, size, int'(step) + 1);
          end
        end else if (!tend) begin
          tcnt <= tcnt + 1'b1;
        end else if (!ph) begin
          ph <= 1'b1; tcnt <= '0;
        end else begin
          ph <= 1'b0; tcnt <= '0;
          if (multi) bcnt <= bcnt + 1'b1;
          else begin
            bcnt <= '0;
            if (pick(code, size, int'(step) + 1) == NONE) begin
              busy <= 1'b0; step <= NONE; idle_st <= 1'b1; done_st <= 1'b1;
            end else step <= pick(code, size, int'(step) + 1);
          end
        end
      end
    end
  end

  logic [TCNT_W-1:0] wl_cnt, rl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin wl_cnt <= '0; rl_cnt <= '0; end
    else begin
      wl_cnt <= we_n ? '0 : wl_cnt + 1'b1;
      rl_cnt <= re_n ? '0 : rl_cnt + 1'b1;
    end
  end

  a_r2_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> wl_cnt == L_WL);
  a_r6_re_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> rl_cnt == L_RP);
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n) && !(cle && ale));
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> step >= $past(step));
  a_r7_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    is_wait |-> (we_n && re_n));
  a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(code) && $stable(size) && $stable(col)));
  a_r10_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (idle_st && done_st));
  a_r11_ce_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ce_n));
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int T_WL = 2, T_WH = 2, T_RP = 2, T_REH = 2, T_WB = 4;
  localparam int AW = 11;
  localparam logic [31:0] VEC [6] = '{32'h4000_0000, 32'h7FC0_0006, 32'h7880_0000,
                                      32'h2010_0000, 32'h0190_0003, 32'h4180_0000};

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, cle, ale, we_n, re_n, io_oe;
  logic [3:0] ce_n;
  logic [3:0] rb_n = 4'b0001;
  logic [7:0] io_out;
  logic [7:0] io_in = 8'h00;

  always #2.5 clk = ~clk;

  nand_seq #(.T_WL(T_WL), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH), .T_WB(T_WB)) u_nand_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n));

  int checks = 0, fails = 0;
  logic [9:0] log_q [64];
  logic [9:0] exp_q [64];
  int n_log = 0, n_exp = 0, n_re = 0, bad_w = 0, bad_r = 0;
  int rd_idx = 0;
  logic [7:0] rd_base = 8'hA0;
  logic [7:0] bufm [64];
  logic [7:0] op1 = 8'h80, op2 = 8'h10, op3 = 8'h70;
  logic [15:0] colv = 16'h3412;
  logic [31:0] rowv = 32'h1156_3C2B;
  logic [31:0] d;
  logic ok;

  initial begin : mon
    int wc, rc;
    logic pw, pr;
    wc = 0; rc = 0; pw = 1; pr = 1;
    forever begin
      @(negedge clk);
      if (!we_n) begin
        wc++;
        if (!io_oe) bad_w++;
      end else if (!pw) begin
        if (wc != T_WL) bad_w++;
        if (n_log < 64) log_q[n_log] = {cle, ale, io_out};
        n_log++;
        wc = 0;
      end
      if (!re_n) rc++;
      else if (!pr) begin
        if (rc != T_RP) bad_r++;
        n_re++;
        rc = 0;
      end
      pw = we_n; pr = re_n;
    end
  end

  initial begin : flash_model
    forever begin
      @(negedge re_n);
      io_in = rd_base + 8'(rd_idx);
      rd_idx++;
    end
  end

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    bus_we = 1; bus_addr = AW'(a); bus_wdata = v;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 v = bus_rdata;
  endtask

  task automatic prog(input int sz);
    wr(0, {op2, op3, 16'h0});
    wr(2, {16'h0, colv});
    wr(3, rowv);
    wr(4, 32'(sz));
  endtask

  task automatic go(input logic [15:0] c);
    n_log = 0; n_re = 0; rd_idx = 0;
    wr(1, {op1, c, 5'b0, 2'b01, 1'b1});
  endtask

  task automatic wait_done(output logic done);
    done = 0;
    for (int k = 0; k < 4000 && !done; k++) begin
      @(negedge clk);
      if (irq) done = 1;
    end
  endtask

  task automatic push(input logic [9:0] e);
    if (n_exp < 64) exp_q[n_exp] = e;
    n_exp++;
  endtask

  task automatic build(input logic [15:0] c, input int sz);
    n_exp = 0;
    for (int s = 0; s <= 12; s++) begin
      if (c[14-s]) begin
        case (s)
          0: push({2'b10, op1});
          1: push({2'b01, colv[7:0]});
          2: push({2'b01, colv[15:8]});
          3: push({2'b01, rowv[7:0]});
          4: push({2'b01, rowv[15:8]});
          5: push({2'b01, rowv[23:16]});
          6: for (int i = 0; i < sz; i++) push({2'b00, bufm[i]});
          7: push({2'b10, op2});
          10: push({2'b10, op3});
          default: ;
        endcase
      end
    end
  endtask

  task automatic cmp_log(input string req);
    int bad;
    bad = -1;
    chk(n_log == n_exp, req, 32'(n_log), 32'(n_exp));
    for (int i = 0; i < n_exp && i < 64; i++)
      if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(0, req, 32'(log_q[bad]), 32'(exp_q[bad]));
    else chk(1, req, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n == 4'hF && we_n && re_n && !cle && !ale && !io_oe && !irq, "R1 pins",
        {ce_n, we_n, re_n, cle, ale, io_oe, irq}, 32'hF_C0 >> 2);
    rst_n = 1;
    rd(1, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(5, d); chk(d == 0, "R1 int", d, 0);

    for (int i = 0; i < 64; i++) bufm[i] = 8'h10 + 8'(i);
    for (int w = 0; w < 16; w++)
      wr(1024 + w, {bufm[4*w], bufm[4*w+1], bufm[4*w+2], bufm[4*w+3]});
    wr(5, 32'h0010_0000);

    // R3 R4 R5: code subsets via table
    for (int v = 0; v < 6; v++) begin
      prog(int'(VEC[v][15:0]));
      build(VEC[v][31:16], int'(VEC[v][15:0]));
      go(VEC[v][31:16]);
      wait_done(ok);
      chk(ok, "R3 completes", 32'(ok), 1);
      cmp_log("R3/R4/R5 sequence");
      rd(1, d); chk(d[0] == 0, "R9 start self-clear", d, 0);
      wr(5, 32'h0016_0000);
    end

    // R6 R7 R9 R11: page read with held busy
    rb_n = 4'b0000;
    rd_base = 8'hA0;
    prog(6);
    build(16'h7EE0, 6);
    go(16'h7EE0);
    repeat (120) @(negedge clk);
    chk(n_re == 0 && !irq, "R7 waits on busy", 32'(n_re), 0);
    rd(1, d); chk(d[0] == 1, "R9 start reads 1 while busy", d, 1);
    chk(ce_n == 4'b1110, "R11 chip enable", 32'(ce_n), 32'hE);
    wr(1, {op1, 16'h4000, 8'h01});
    wr(2, 32'h0000_FFFF);
    rd(2, d); chk(d == 32'h3412, "R9 col write ignored while busy", d, 32'h3412);
    rb_n = 4'b0001;
    wait_done(ok);
    chk(ok, "R7 ends on selected line", 32'(ok), 1);
    cmp_log("R9 busy start ignored");
    chk(n_re == 6, "R6 read pulses", 32'(n_re), 6);
    rd(1024, d); chk(d == 32'hA0A1A2A3, "R6 word0", d, 32'hA0A1A2A3);
    rd(1025, d); chk(d == 32'hA4A51617, "R6 word1 partial", d, 32'hA4A51617);
    chk(ce_n == 4'hF, "R11 idle ce", 32'(ce_n), 32'hF);
    wr(5, 32'h0016_0000);

    // R8 status and ID
    rd_base = 8'hC0;
    build(16'h001C, 0);
    go(16'h001C);
    wait_done(ok);
    cmp_log("R8 cmd3");
    rd(6, d); chk(d == 32'hC0, "R8 status", d, 32'hC0);
    rd(7, d); chk(d == 32'hC1C2C3C4, "R8 id", d, 32'hC1C2C3C4);

    // R10 flags and clears
    rd(5, d); chk(d == 32'h6010_0000, "R10 flags", d, 32'h6010_0000);
    wr(5, 32'h0012_0000);
    rd(5, d); chk(d == 32'h4010_0000 && !irq, "R10 clear idle", d, 32'h4010_0000);
    wr(5, 32'h0014_0000);
    rd(5, d); chk(d == 32'h0010_0000, "R10 clear done", d, 32'h0010_0000);

    // R5 zero-size read skipped
    prog(0);
    build(16'h4020, 0);
    go(16'h4020);
    wait_done(ok);
    cmp_log("R5 zero size");
    chk(n_re == 0, "R5 zero size no read", 32'(n_re), 0);
    wr(5, 32'h0000_0000);

    // R9 R10 empty code, interrupt disabled
    go(16'h0000);
    repeat (3) @(negedge clk);
    rd(5, d); chk(d == 32'h6000_0000 && !irq, "R9/R10 empty code", d, 32'h6000_0000);
    chk(n_log == 0, "R9 empty code no cycles", 32'(n_log), 0);

    chk(bad_w == 0, "R2 write pulse shape", 32'(bad_w), 0);
    chk(bad_r == 0, "R6 read pulse width", 32'(bad_r), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule